// File: doc/BRIEF.md
# Block-Write Serial Configuration Slave

This block is a two-wire serial slave that keeps a small bank of 8-bit configuration bytes and presents them on a flat output vector for the surrounding logic. A system clock samples the bus clock and data lines through synchronisers. The slave drives the data line open-drain: it can only pull the line low, so the bus is the wired AND of the master and the slave. One 7-bit device address is decoded, with the direction bit carried in bit 0 of the address byte.

A write transaction is a block write with a fixed preamble. After the address byte the master must send two more bytes, normally a command byte and a count byte. The slave acknowledges both and discards their contents. Every byte after that loads the next register, starting at register 0 in every transaction. The transaction continues until STOP. A read transaction streams register 0, then 1 and onward, for as long as the master keeps acknowledging. There is no register pointer and no random access.

Top module: `cfg_serial_slave`

## Requirements
- R1: The address byte 0xD2 (7-bit address 0x69, bit 0 = 0) is acknowledged as a write, and 0xD3 (bit 0 = 1) is acknowledged as a read. The slave acknowledges by pulling SDA low during the ninth clock of the byte.
- R2: An address byte whose upper seven bits are not 0x69 is not acknowledged. Until the next START, the slave acknowledges no further byte and changes no register.
- R3: In a write, the two bytes that follow the address byte are acknowledged and have no effect on any register, whatever their values.
- R4: In a write, the third and later bytes after the address are acknowledged and stored in order into registers 0, 1, 2 and so on. Register k appears on cfg_bytes[8k+7:8k], updated once the byte's eighth bit has been received, and at most one register changes at a time.
- R5: When STOP arrives in the middle of a byte, the bits already received for that byte are dropped, and every register written earlier keeps its value.
- R6: In a read, data is sent MSB first, starting with register 0 and moving to the next register each time the master acknowledges. After a master NACK the slave releases SDA.
- R7: After reset, register 0 holds 0x00 and registers 1 to 5 hold 0xFF.
- R8: Write data bytes beyond the last register are acknowledged but discarded. Reads beyond the last register return 0xFF.
- R9: A repeated START restarts the transaction, and the next data byte in either direction uses register 0.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When high, the data line is pulled low |
| cfg_bytes | output | NUM_BYTES*8 | Configuration registers, register k in bits 8k+7:8k |

## Verification
The assertions assume that each SCL low phase lasts longer than the synchroniser delay plus one clock. Under that assumption, register updates and SDA changes made after a falling edge are seen while the input SCL is still low. They also assume that the master changes SDA only while SCL is low, except to signal START and STOP. The bench master runs every bus phase for eight system clocks and drives data only in the middle of the low phase, so every transaction stays within these assumptions. Random transactions mix write lengths, partial bytes, reads past the end and foreign addresses, and are interleaved with directed repeated-START sequences.

// File: rtl/cfg_serial_slave.sv
`timescale 1ns/1ps
module cfg_serial_slave #(
  parameter int         NUM_BYTES   = 6,
  parameter int         DUMMY_BYTES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter logic [7:0] RST_FIRST   = 8'h00,
  parameter logic [7:0] RST_OTHER   = 8'hFF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  output logic [NUM_BYTES*8-1:0] cfg_bytes
);
  localparam int IDXW = $clog2(NUM_BYTES + 1);
  localparam int DW   = $clog2(DUMMY_BYTES + 1);
  localparam logic [IDXW-1:0] IDX_END = IDXW'(NUM_BYTES);
  localparam logic [DW-1:0]   DUM_END = DW'(DUMMY_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WR, S_RD, S_IGN} state_t;

  state_t          state;
  logic [2:0]      scl_s, sda_s;
  logic [3:0]      bitcnt;
  logic [7:0]      shreg;
  logic [IDXW-1:0] byte_idx;
  logic [DW-1:0]   dcnt;

  wire scl      = scl_s[1];
  wire sda      = sda_s[1];
  wire scl_rise = scl_s[1] & ~scl_s[2];
  wire scl_fall = ~scl_s[1] & scl_s[2];
  wire start    = scl_s[1] & scl_s[2] & sda_s[2] & ~sda_s[1];
  wire stop     = scl_s[1] & scl_s[2] & ~sda_s[2] & sda_s[1];
  wire in_range = byte_idx < IDX_END;

  logic [NUM_BYTES*8+7:0] rd_ext;
  logic [7:0]             rd_byte;
  assign rd_ext  = {8'hFF, cfg_bytes};
  assign rd_byte = rd_ext[{byte_idx, 3'b000} +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s     <= 3'b111;
      sda_s     <= 3'b111;
      state     <= S_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      byte_idx  <= '0;
      dcnt      <= '0;
      sda_oe    <= 1'b0;
      cfg_bytes <= {{(NUM_BYTES-1){RST_OTHER}}, RST_FIRST};
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
      if (start) begin
        state    <= S_ADDR;
        bitcnt   <= '0;
        byte_idx <= '0;
        dcnt     <= '0;
        sda_oe   <= 1'b0;
      end else if (stop) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        case (state)
          S_ADDR, S_WR: begin
            if (bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda};
              bitcnt <= bitcnt + 4'd1;
            end else if (bitcnt == 4'd8) begin
              bitcnt <= 4'd9;
            end
          end
          S_RD: begin
            if (bitcnt < 4'd8) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (bitcnt == 4'd8) begin
              if (sda) begin
                state <= S_IGN;
              end else begin
                bitcnt <= 4'd9;
                if (in_range) byte_idx <= byte_idx + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        case (state)
          S_ADDR: begin
            if (bitcnt == 4'd8) begin
              if (shreg[7:1] == DEV_ADDR) sda_oe <= 1'b1;
              else state <= S_IGN;
            end else if (bitcnt == 4'd9) begin
              bitcnt <= '0;
              if (shreg[0]) begin
                state  <= S_RD;
                shreg  <= rd_byte;
                sda_oe <= ~rd_byte[7];
              end else begin
                state  <= S_WR;
                sda_oe <= 1'b0;
              end
            end
          end
          S_WR: begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b1;
              if (dcnt < DUM_END) begin
                dcnt <= dcnt + 1'b1;
              end else if (in_range) begin
                cfg_bytes[{byte_idx, 3'b000} +: 8] <= shreg;
                byte_idx <= byte_idx + 1'b1;
              end
            end else if (bitcnt == 4'd9) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
            end
          end
          S_RD: begin
            if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end else if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
            end else if (bitcnt == 4'd9) begin
              bitcnt <= '0;
              shreg  <= rd_byte;
              sda_oe <= ~rd_byte[7];
            end
          end
          default: ;
        endcase
      end
    end
  end

  wire unused_ok = scl;
endmodule

module cfg_serial_slave_chk #(
  parameter int         NUM_BYTES = 6,
  parameter logic [7:0] RST_FIRST = 8'h00,
  parameter logic [7:0] RST_OTHER = 8'hFF
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scl_i,
  input logic                   sda_oe,
  input logic [NUM_BYTES*8-1:0] cfg_bytes
);
  logic [NUM_BYTES*8-1:0] prev_cfg;
  logic [NUM_BYTES-1:0]   chg_mask;

  always_ff @(posedge clk) prev_cfg <= cfg_bytes;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_chg
    assign chg_mask[i] = cfg_bytes[i*8 +: 8] != prev_cfg[i*8 +: 8];
  end

  // R7
  reset_value_chk: assert property (@(posedge clk)
    !rst_n |=> (cfg_bytes == {{(NUM_BYTES-1){RST_OTHER}}, RST_FIRST}));

  // R4
  cfg_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_bytes) |-> !scl_i);

  // R4
  one_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chg_mask) <= 1);

  // R10
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);
endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(
  .NUM_BYTES(NUM_BYTES), .RST_FIRST(RST_FIRST), .RST_OTHER(RST_OTHER)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .cfg_bytes(cfg_bytes)
);

// File: tb/cfg_serial_slave_test.sv
`timescale 1ns/1ps
module cfg_serial_slave_test;
  localparam int NB = 6;
  localparam int Q  = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [NB*8-1:0] cfg;
  assign sda_bus = m_sda & ~sda_oe;

  cfg_serial_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .cfg_bytes(cfg)
  );

  int errs = 0;
  int checks = 0;
  logic [7:0] exp_b [NB];
  logic [7:0] wbuf [16];

  function automatic logic [NB*8-1:0] exp_vec();
    logic [NB*8-1:0] v;
    for (int i = 0; i < NB; i++) v[i*8 +: 8] = exp_b[i];
    return v;
  endfunction

  function automatic logic [7:0] exp_rd(input int i);
    return (i < NB) ? exp_b[i] : 8'hFF;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw; repeat (Q) @(negedge clk); endtask
  task automatic bus_start; m_sda = 1; qw; m_scl = 1; qw; m_sda = 0; qw; m_scl = 0; qw; endtask
  task automatic bus_stop; m_sda = 0; qw; m_scl = 1; qw; m_sda = 1; qw; qw; endtask
  task automatic send_bit(input bit b); m_sda = b; qw; m_scl = 1; qw; qw; m_scl = 0; qw; endtask
  task automatic get_bit(output bit b); m_sda = 1; qw; m_scl = 1; qw; b = sda_bus; qw; m_scl = 0; qw; endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    send_bit(~mack);
  endtask

  task automatic do_write(input logic [7:0] addr, input int n, input int partial, input bit do_stop);
    bit ack;
    bit hit;
    hit = (addr[7:1] == 7'h69);
    bus_start;
    send_byte(addr, ack);
    chk(hit ? "R1 write address ack" : "R2 foreign address nack", ack, hit);
    for (int i = 0; i < 2; i++) begin
      send_byte(8'($urandom), ack);
      chk(hit ? "R3 dummy ack" : "R2 ignored ack", ack, hit);
      chk(hit ? "R3 dummy no effect" : "R2 no effect", cfg, exp_vec());
    end
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      if (hit && i < NB) exp_b[i] = wbuf[i];
      chk(!hit ? "R2 ignored ack" : (i < NB ? "R4 data ack" : "R8 excess ack"), ack, hit);
      chk(!hit ? "R2 no effect" : (i < NB ? "R4 data stored" : "R8 excess dropped"), cfg, exp_vec());
    end
    if (partial > 0) begin
      for (int i = 0; i < partial; i++) send_bit(1'($urandom));
      bus_stop;
      chk("R5 partial byte dropped", cfg, exp_vec());
    end else if (do_stop) begin
      bus_stop;
      chk("R5 stop keeps bytes", cfg, exp_vec());
    end
  endtask

  task automatic do_read(input logic [7:0] addr, input int n);
    bit ack;
    bit hit;
    logic [7:0] d;
    hit = (addr[7:1] == 7'h69);
    bus_start;
    send_byte(addr, ack);
    chk(hit ? "R1 read address ack" : "R2 foreign read nack", ack, hit);
    if (hit) begin
      for (int i = 0; i < n; i++) begin
        recv_byte(i < n - 1, d);
        chk(i < NB ? "R6 read data" : "R8 read past end", d, exp_rd(i));
      end
      chk("R6 release after nack", sda_oe, 1'b0);
    end
    bus_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    exp_b[0] = 8'h00;
    for (int i = 1; i < NB; i++) exp_b[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 reset value", cfg, exp_vec());
    chk("R10 idle release", sda_oe, 1'b0);

    do_read(8'hD3, 8);

    for (int i = 0; i < 16; i++) wbuf[i] = 8'h11 * (i + 1);
    do_write(8'hD2, 6, 0, 1);
    do_read(8'hD3, 6);

    for (int i = 0; i < 16; i++) wbuf[i] = 8'($urandom);
    do_write(8'hD2, 8, 0, 1);
    do_read(8'hD3, 7);

    for (int i = 0; i < 16; i++) wbuf[i] = 8'($urandom);
    do_write(8'hD2, 2, 3, 1);
    do_write(8'hD2, 0, 5, 1);

    for (int i = 0; i < 16; i++) wbuf[i] = 8'($urandom);
    do_write(8'hA4, 4, 0, 1);
    do_read(8'hA1, 2);
    do_read(8'hD3, 6);

    for (int i = 0; i < 16; i++) wbuf[i] = 8'($urandom);
    do_write(8'hD2, 2, 0, 0);
    wbuf[0] = 8'h5A;
    do_write(8'hD2, 1, 0, 1);
    chk("R9 restart write reg0", cfg[7:0], 8'h5A);
    wbuf[0] = 8'hC3;
    do_write(8'hD2, 1, 0, 0);
    do_read(8'hD3, 2);
    chk("R9 restart kept reg1", cfg[15:8], exp_b[1]);

    for (int t = 0; t < 16; t++) begin
      int r;
      r = $urandom % 10;
      for (int i = 0; i < 16; i++) wbuf[i] = 8'($urandom);
      if (r < 5) do_write(8'hD2, $urandom % 9, ($urandom % 4 == 0) ? 1 + $urandom % 7 : 0, 1);
      else if (r < 8) do_read(8'hD3, 1 + $urandom % 8);
      else begin
        logic [6:0] a;
        a = 7'h69 ^ 7'(1 + $urandom % 127);
        do_write({a, 1'b0}, 1 + $urandom % 4, 0, 1);
      end
    end
    do_read(8'hD3, 6);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule